// File: doc/BRIEF.md
# Edge-Triggered Channel-OR Trigger Unit

This block forms fast trigger signals from 192 discriminated detector channels, organised as six groups of 32. Each channel input is synchronised into the core clock domain and watched for rising edges. When an enabled channel in a group rises, that group's output fires for exactly one clock cycle. At the 250 MHz core clock, one cycle is 4 ns. A level that stays high, or a falling edge, produces nothing.

The six group pulses are merged into one combined pulse. The combined pulse is stretched to a length in cycles that software programs, and a new edge during the pulse starts the count again. A final output merges the combined pulse with an external generic input, so downstream logic can take either source from one pin.

Configuration uses a simple write-only register port. There are six 32-bit channel enable masks and one width field. All of these registers clear on reset, so every channel starts disabled.

Top module: `chan_or_trigger`

## Requirements
- R1: Group output bit g (0..5) responds only to channels 32g to 32g+31 of `chan_in`.
- R2: A group pulse is caused only by a low-to-high transition of an enabled channel. A channel held high, or a falling channel, causes no further pulse.
- R3: A group pulse lasts exactly one clock cycle. It appears on the third rising clock edge after the input change is first sampled: two synchroniser stages, then the pulse register.
- R4: The enable mask of group g is written at byte address 0x60 + 4g. Bit i set to 1 enables channel i of that group. A write applies from the next cycle, and all masks reset to zero.
- R5: The combined output rises one cycle after any group pulse. It stays high for W cycles, where W is `wr_data[15:8]` as last written to address 0x78.
- R6: A width value of 0 gives a combined pulse of one cycle.
- R7: A group pulse that arrives while the combined pulse is active restarts the count. The combined pulse then ends W cycles after the new start.
- R8: The final output is registered. It is high one cycle after the combined output is high, and it is also high three cycles after `gen_in` goes high (two synchroniser stages, then the output register).
- R9: A write to any address other than the seven defined ones changes no mask and does not change the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, 250 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_in | input | 192 | Asynchronous discriminator inputs, group g in bits 32g+31:32g |
| gen_in | input | 1 | Asynchronous external generic input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| grp_pulse | output | 6 | One-cycle rising-edge pulse per group |
| comb_pulse | output | 1 | Stretched OR of all group pulses |
| final_pulse | output | 1 | Registered OR of combined pulse and generic input |

## Verification
Each kind of internal fault shows up at the ports within a few cycles of the stimulus that exposes it:
- A stale or missing edge-history flop makes a group pulse last two cycles, or fire on a held level. Either shows on `grp_pulse` in the fourth cycle after the input change.
- A mask decoded at the wrong offset makes the wrong group respond, or no group respond, three cycles after an edge.
- A width counter that is off by one, or that ignores a restart, moves the falling edge of `comb_pulse` and of `final_pulse` by a cycle or more.

The bench checks every output on every cycle against an independently scheduled timeline. Spurious activity in quiet cycles therefore counts as an error, as does a missing pulse.

// File: rtl/chan_or_pkg.sv
package chan_or_pkg;
  localparam int NUM_GROUPS = 6;
  localparam int GROUP_W    = 32;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int LEN_W      = 8;
  localparam int LEN_LSB    = 8;
  localparam logic [ADDR_W-1:0] MASK_BASE = 8'h60;
  localparam logic [ADDR_W-1:0] LEN_ADDR  = 8'h78;

  // byte address of the enable mask for a group
  function automatic logic [ADDR_W-1:0] mask_addr(input int g);
    return MASK_BASE + ADDR_W'(4 * g);
  endfunction

  // programmed width converted to a cycle count (zero means one cycle)
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] w);
    return (w == '0) ? LEN_W'(1) : w;
  endfunction
endpackage

// File: rtl/chan_or_regs.sv
module chan_or_regs
  import chan_or_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_GROUPS-1:0][GROUP_W-1:0] masks,
  output logic [LEN_W-1:0]                 len_field
);
  logic [NUM_GROUPS-1:0] mask_hit;
  logic                  len_hit;
  logic                  any_hit;

  assign len_hit = wr_en && (wr_addr == LEN_ADDR);
  assign any_hit = len_hit || (|mask_hit);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    assign mask_hit[g] = wr_en && (wr_addr == mask_addr(g));

    always_ff @(posedge clk) begin
      if (!rst_n)           masks[g] <= '0;
      else if (mask_hit[g]) masks[g] <= wr_data[GROUP_W-1:0];
    end

    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == mask_addr(g)) |=> masks[g] == $past(wr_data[GROUP_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       len_field <= '0;
    else if (len_hit) len_field <= wr_data[LEN_LSB +: LEN_W];
  end

  p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_hit) |=> ($stable(masks) && $stable(len_field)));
endmodule

// File: rtl/chan_or_group.sv
module chan_or_group
  import chan_or_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] chans,
  input  logic [GROUP_W-1:0] enable,
  output logic               pulse
);
  logic [GROUP_W-1:0] meta_q, sync_q, hist_q;
  logic [GROUP_W-1:0] rise;
  logic               rise_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= chans;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise     = sync_q & ~hist_q & enable;
  assign rise_any = |rise;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= rise_any;
  end

  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) == '0) |-> !pulse);
  p_level_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sync_q) == $past(hist_q)) |-> !pulse);
endmodule

// File: rtl/chan_or_stretch.sv
module chan_or_stretch
  import chan_or_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LEN_W-1:0] len_field,
  input  logic             gen_in,
  output logic             comb_q,
  output logic             final_q
);
  logic [LEN_W-1:0] cnt_q;
  logic             gen_meta, gen_sync;
  logic             cnt_live;

  assign cnt_live = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      comb_q <= 1'b0;
    end else if (trig) begin
      cnt_q  <= eff_len(len_field) - LEN_W'(1);
      comb_q <= 1'b1;
    end else if (cnt_live) begin
      cnt_q  <= cnt_q - LEN_W'(1);
    end else begin
      comb_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_meta <= 1'b0;
      gen_sync <= 1'b0;
      final_q  <= 1'b0;
    end else begin
      gen_meta <= gen_in;
      gen_sync <= gen_meta;
      final_q  <= comb_q | gen_sync;
    end
  end

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> comb_q);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_q && cnt_live) |=> comb_q);
  p_final_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    comb_q |=> final_q);
  p_final_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    final_q |-> ($past(comb_q) || $past(gen_sync)));
endmodule

// File: rtl/chan_or_trigger.sv
module chan_or_trigger
  import chan_or_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0]    chan_in,
  input  logic                             gen_in,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_GROUPS-1:0]            grp_pulse,
  output logic                             comb_pulse,
  output logic                             final_pulse
);
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] masks;
  logic [LEN_W-1:0]                   len_field;
  logic                               grp_any;

  chan_or_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .masks(masks), .len_field(len_field)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    chan_or_group u_grp (
      .clk(clk), .rst_n(rst_n),
      .chans(chan_in[g*GROUP_W +: GROUP_W]),
      .enable(masks[g]),
      .pulse(grp_pulse[g])
    );
  end

  assign grp_any = |grp_pulse;

  chan_or_stretch u_stretch (
    .clk(clk), .rst_n(rst_n), .trig(grp_any), .len_field(len_field),
    .gen_in(gen_in), .comb_q(comb_pulse), .final_q(final_pulse)
  );

  p_comb_after_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comb_pulse) |-> $past(grp_any));
endmodule

// File: tb/tb_chan_or_trigger.sv
module tb_chan_or_trigger;
  localparam int CLK_PERIOD = 4;
  localparam int NCH = 192;
  localparam int WATCHDOG = 200000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] chan_in = '0;
  logic           gen_in = 1'b0;
  logic           wr_en = 1'b0;
  logic [7:0]     wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic [5:0]     grp_pulse;
  logic           comb_pulse, final_pulse;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  logic [5:0] exp_g [int];
  logic       exp_c [int];
  logic       exp_f [int];
  string      exp_r [int];

  chan_or_trigger dut (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .gen_in(gen_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .grp_pulse(grp_pulse), .comb_pulse(comb_pulse), .final_pulse(final_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard entry: OR-merged expectation for one cycle
  task automatic sched(int c, logic [5:0] g, logic cb, logic f, string r);
    if (!exp_g.exists(c)) begin exp_g[c] = '0; exp_c[c] = 0; exp_f[c] = 0; exp_r[c] = r; end
    exp_g[c] |= g; exp_c[c] |= cb; exp_f[c] |= f;
  endtask

  // channel edge driven in cycle c: group pulse c+3, comb c+4.., final c+5..
  task automatic expect_edge(int c, logic [5:0] g, int len, string r);
    sched(c + 3, g, 0, 0, r);
    for (int k = 0; k < len; k++) begin
      sched(c + 4 + k, '0, 1, 0, r);
      sched(c + 5 + k, '0, 0, 1, r);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_reg(logic [7:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 0;
  endtask

  // monitor: compares every cycle, quiet cycles must be all zero
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] eg; logic ec, ef; string r;
      eg = '0; ec = 0; ef = 0; r = "R2 quiet cycle";
      if (exp_g.exists(cyc)) begin
        eg = exp_g[cyc]; ec = exp_c[cyc]; ef = exp_f[cyc]; r = exp_r[cyc];
        exp_g.delete(cyc); exp_c.delete(cyc); exp_f.delete(cyc); exp_r.delete(cyc);
      end
      n_checks++;
      if (grp_pulse !== eg || comb_pulse !== ec || final_pulse !== ef) begin
        n_fail++;
        $display("FAIL %s cyc %0d: grp=%b comb=%b final=%b expected grp=%b comb=%b final=%b",
                 r, cyc, grp_pulse, comb_pulse, final_pulse, eg, ec, ef);
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: got running, expected done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : driver
    int c;
    tick(3);
    rst_n = 1;
    tick(1);
    // R4 reset: all masks zero, toggling inputs must give nothing
    chan_in = '1; tick(10); chan_in = '0; tick(10);

    // R4 R5 R2: group 0 channel 5, width 3, held high then dropped
    write_reg(8'h60, 32'h0000_0020);
    write_reg(8'h78, 32'h0000_0300);
    tick(2);
    c = cyc; chan_in[5] = 1; expect_edge(c, 6'b000001, 3, "R2 R3 R5 group0 edge");
    tick(25); chan_in[5] = 0; tick(10);

    // R4: disabled neighbour channel 6 gives nothing
    chan_in[6] = 1; tick(10); chan_in[6] = 0; tick(10);

    // R1: each other group via its top channel
    for (int g = 1; g < 6; g++) begin
      write_reg(8'h60 + 8'(4*g), 32'h8000_0000);
      tick(2);
      c = cyc; chan_in[32*g+31] = 1; expect_edge(c, 6'(1 << g), 3, "R1 group select");
      tick(12); chan_in[32*g+31] = 0; tick(6);
    end

    // R1: all six groups together
    c = cyc;
    for (int g = 0; g < 6; g++) chan_in[32*g + (g == 0 ? 5 : 31)] = 1;
    expect_edge(c, 6'h3f, 3, "R1 all groups");
    tick(12); chan_in = '0; tick(6);

    // R6: width 0 gives one cycle
    write_reg(8'h78, 32'h0000_0000);
    tick(2);
    c = cyc; chan_in[5] = 1; expect_edge(c, 6'b000001, 1, "R6 zero width");
    tick(10); chan_in[5] = 0; tick(6);

    // R7: retrigger restarts the count (width 5)
    write_reg(8'h60, 32'h0000_0003);
    write_reg(8'h78, 32'hFFFF_05FF);
    tick(2);
    c = cyc; chan_in[0] = 1; expect_edge(c, 6'b000001, 5, "R7 first edge");
    tick(3); chan_in[1] = 1; expect_edge(c + 3, 6'b000001, 5, "R7 restart");
    tick(20); chan_in[1:0] = '0; tick(6);

    // R8: generic input alone, 4 cycles wide
    c = cyc; gen_in = 1;
    for (int k = 0; k < 4; k++) sched(c + 3 + k, '0, 0, 1, "R8 generic path");
    tick(4); gen_in = 0; tick(10);

    // R9: stray writes leave masks and width unchanged
    write_reg(8'h7C, 32'h0000_0000);
    write_reg(8'h5C, 32'h0000_0000);
    write_reg(8'h79, 32'h0000_0100);
    tick(2);
    c = cyc; chan_in[0] = 1; expect_edge(c, 6'b000001, 5, "R9 stray write ignored");
    tick(15); chan_in[0] = 0; tick(6);

    // R4: clearing mask disables the channel from the next cycle
    write_reg(8'h60, 32'h0000_0000);
    chan_in[0] = 1; tick(10); chan_in[0] = 0; tick(10);

    if (exp_g.size() != 0) begin
      n_fail++;
      $display("FAIL R3 scoreboard: %0d entries left, expected 0", exp_g.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule